// File: doc/BRIEF.md
# Shift-Add Multiply Step Datapath

This block multiplies two unsigned operands without a hardware multiplier. It keeps three registers that play the roles of the top three entries of an operand stack: an accumulator `T`, a second register `N1` and a third register `N2`. `T` accumulates and ends as the upper half of the product. `N1` first holds the multiplier and ends as the lower half. `N2` holds the multiplicand. One multiply step takes one clock. In that clock the block adds `N2` into `T` when the lowest bit of `N1` is set. It then shifts the joined value `T:N1` right by one place. The carry out of the addition enters at the top.

The datapath can be driven one step at a time through a load strobe and a step strobe. It can also be run by a built-in sequencer. After a start pulse, the sequencer loads the operands and clears the accumulator. It then issues one step per bit of the operand width and finally discards the multiplicand. With the default 16-bit width, the whole operation takes 19 clocks, and a one-cycle done pulse marks its end.

Top module: `shmul_core`

## Requirements
- R1: After reset, `t_o`, `n1_o` and `n2_o` are zero and `busy_o` and `done_o` are low.
- R2: While idle, a `load_i` pulse sets `n1_o` to `mplier_i`, `n2_o` to `mcand_i` and `t_o` to zero at the next clock edge.
- R3: While idle and with `load_i` low, a `step_i` clock performs one step. If `n1_o` bit 0 is 1, `n2_o` is added to `t_o` as a W+1-bit sum, otherwise the sum is `t_o`. The new `t_o` is sum bits W down to 1, so the carry becomes the new most significant bit. The new `n1_o` is sum bit 0 followed by `n1_o` bits W-1 down to 1.
- R4: A step never changes `n2_o`.
- R5: Starting from a load, W consecutive steps leave the full unsigned product in `prod_o` = {`t_o`, `n1_o`}, with `t_o` as the upper half and `n1_o` as the lower half.
- R6: A `start_i` pulse while idle raises `busy_o` after that edge (edge 0). `done_o` is high for exactly one cycle, after edge W+2 (edge 18 for W=16), which gives W+3 clocks in total. `busy_o` falls at that same edge.
- R7: When `done_o` is high, `prod_o` holds `mplier_i`×`mcand_i` as sampled at the start edge, and `n2_o` is zero because the multiplicand has been discarded.
- R8: While `busy_o` is high, `start_i`, `load_i` and `step_i` are ignored. The run finishes on its original schedule with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a full sequenced multiply |
| load_i | input | 1 | Manual operand load while idle |
| step_i | input | 1 | Manual single multiply step while idle |
| mplier_i | input | W | Multiplier operand |
| mcand_i | input | W | Multiplicand operand |
| t_o | output | W | Accumulator / upper product register |
| n1_o | output | W | Multiplier / lower product register |
| n2_o | output | W | Multiplicand register |
| prod_o | output | 2W | Concatenation {t_o, n1_o} |
| busy_o | output | 1 | Sequenced multiply in progress |
| done_o | output | 1 | One-cycle end-of-multiply pulse |

## Verification
The embedded properties check on every cycle the following:
- a step leaves the multiplicand untouched and shifts the multiplier bits down;
- a step with a clear low bit halves the accumulator;
- cleanup zeroes the multiplicand;
- `done_o` is a single-cycle pulse that arrives exactly W+2 busy cycles after the start edge;
- no load happens while busy.

Only the bench scenarios can show the arithmetic result: the complete products, including the carry-heavy all-ones case, and the fact that a second start or manual strobe in the middle of a run leaves the original product intact.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_LOAD  = 3'd1,
      CMD_CLR   = 3'd2,
      CMD_STEP  = 3'd3,
      CMD_CLEAN = 3'd4
   } shmul_cmd_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_CLEAR = 2'd1,
      SQ_RUN   = 2'd2,
      SQ_CLEAN = 2'd3
   } shmul_state_e;

endpackage

// File: rtl/shmul_step.sv
module shmul_step #(
   parameter int W = 16
) (
   input  logic [W-1:0] t_i,
   input  logic [W-1:0] n1_i,
   input  logic [W-1:0] n2_i,
   output logic [W-1:0] t_nx_o,
   output logic [W-1:0] n1_nx_o
);
   localparam int SW = W + 1;

   logic [W-1:0]  addend;
   logic [SW-1:0] sum;

   generate
      if (W < 2) begin : g_bad_w
         $error("shmul_step: W must be at least 2");
      end
      for (genvar i = 0; i < W; i++) begin : g_mask
         assign addend[i] = n2_i[i] & n1_i[0];
      end
   endgenerate

   assign sum     = {1'b0, t_i} + {1'b0, addend};
   assign t_nx_o  = sum[SW-1:1];
   assign n1_nx_o = {sum[0], n1_i[W-1:1]};

endmodule

// File: rtl/shmul_regs.sv
module shmul_regs
   import shmul_pkg::*;
#(
   parameter int W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  shmul_cmd_e    cmd_i,
   input  logic [W-1:0]  mplier_i,
   input  logic [W-1:0]  mcand_i,
   output logic [W-1:0]  t_o,
   output logic [W-1:0]  n1_o,
   output logic [W-1:0]  n2_o
);
   logic [W-1:0] t_q, n1_q, n2_q;
   logic [W-1:0] t_step, n1_step;

   shmul_step #(.W(W)) u_step (
      .t_i     (t_q),
      .n1_i    (n1_q),
      .n2_i    (n2_q),
      .t_nx_o  (t_step),
      .n1_nx_o (n1_step)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_q  <= '0;
         n1_q <= '0;
         n2_q <= '0;
      end else begin
         unique case (cmd_i)
            CMD_LOAD: begin
               t_q  <= '0;
               n1_q <= mplier_i;
               n2_q <= mcand_i;
            end
            CMD_CLR:   t_q <= '0;
            CMD_STEP: begin
               t_q  <= t_step;
               n1_q <= n1_step;
            end
            CMD_CLEAN: n2_q <= '0;
            default: ;
         endcase
      end
   end

   assign t_o  = t_q;
   assign n1_o = n1_q;
   assign n2_o = n2_q;

   // R4
   n2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_STEP) |=> $stable(n2_q));

   // R3
   n1_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_STEP) |=> (n1_q[W-2:0] == $past(n1_q[W-1:1])));

   // R3
   t_halve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_STEP && !n1_q[0]) |=> (t_q == ($past(t_q) >> 1)));

   // R7
   clean_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_CLEAN) |=> (n2_q == '0 && $stable(t_q) && $stable(n1_q)));

endmodule

// File: rtl/shmul_seq.sv
module shmul_seq
   import shmul_pkg::*;
#(
   parameter int W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       load_i,
   input  logic       step_i,
   output shmul_cmd_e cmd_o,
   output logic       busy_o,
   output logic       done_o
);
   localparam int STEPS = W;
   localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam int LAST  = STEPS - 1;
   localparam int TOTAL = STEPS + 3;
   localparam int BCW   = $clog2(TOTAL + 1);

   shmul_state_e st_q, st_nx;
   logic [CW-1:0] k_q;
   logic          done_q;

   always_comb begin
      st_nx = st_q;
      cmd_o = CMD_NONE;
      unique case (st_q)
         SQ_IDLE: begin
            if (start_i) begin
               cmd_o = CMD_LOAD;
               st_nx = SQ_CLEAR;
            end else if (load_i) begin
               cmd_o = CMD_LOAD;
            end else if (step_i) begin
               cmd_o = CMD_STEP;
            end
         end
         SQ_CLEAR: begin
            cmd_o = CMD_CLR;
            st_nx = SQ_RUN;
         end
         SQ_RUN: begin
            cmd_o = CMD_STEP;
            if (k_q == CW'(LAST)) st_nx = SQ_CLEAN;
         end
         SQ_CLEAN: begin
            cmd_o = CMD_CLEAN;
            st_nx = SQ_IDLE;
         end
         default: st_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         k_q    <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_nx;
         done_q <= (st_q == SQ_CLEAN);
         if (st_q == SQ_RUN) k_q <= k_q + 1'b1;
         else                k_q <= '0;
      end
   end

   assign busy_o = (st_q != SQ_IDLE);
   assign done_o = done_q;

   // busy-cycle counter used only by the checks below
   logic [BCW-1:0] bcnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      bcnt_q <= '0;
      else if (busy_o) bcnt_q <= bcnt_q + 1'b1;
      else             bcnt_q <= '0;
   end

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (bcnt_q == BCW'(TOTAL - 1) && !busy_o));

   // R8
   no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cmd_o != CMD_LOAD));

   // R8
   stay_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && st_q != SQ_CLEAN) |=> busy_o);

endmodule

// File: rtl/shmul_core.sv
module shmul_core
   import shmul_pkg::*;
#(
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic           load_i,
   input  logic           step_i,
   input  logic [W-1:0]   mplier_i,
   input  logic [W-1:0]   mcand_i,
   output logic [W-1:0]   t_o,
   output logic [W-1:0]   n1_o,
   output logic [W-1:0]   n2_o,
   output logic [2*W-1:0] prod_o,
   output logic           busy_o,
   output logic           done_o
);
   shmul_cmd_e cmd;

   shmul_seq #(.W(W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_i  (load_i),
      .step_i  (step_i),
      .cmd_o   (cmd),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   shmul_regs #(.W(W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_i    (cmd),
      .mplier_i (mplier_i),
      .mcand_i  (mcand_i),
      .t_o      (t_o),
      .n1_o     (n1_o),
      .n2_o     (n2_o)
   );

   assign prod_o = {t_o, n1_o};

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (t_o == '0 && n1_o == '0 && n2_o == '0 && !busy_o && !done_o));

endmodule

// File: tb/shmul_core_bench.sv
module shmul_core_bench;
   localparam int W = 16;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, load_i = 1'b0, step_i = 1'b0;
   logic [W-1:0] mplier_i = '0, mcand_i = '0;
   logic [W-1:0] t_o, n1_o, n2_o;
   logic [2*W-1:0] prod_o;
   logic busy_o, done_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shmul_core #(.W(W)) u_shmul_core (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_i),
      .step_i(step_i), .mplier_i(mplier_i), .mcand_i(mcand_i),
      .t_o(t_o), .n1_o(n1_o), .n2_o(n2_o), .prod_o(prod_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2*W-1:0] ref_step(input logic [W-1:0] t,
                                               input logic [W-1:0] n1,
                                               input logic [W-1:0] n2);
      logic [W:0] s;
      s = {1'b0, t} + (n1[0] ? {1'b0, n2} : '0);
      return {s[W:1], s[0], n1[W-1:1]};
   endfunction

   task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
      mplier_i = a; mcand_i = b; load_i = 1'b1;
      @(negedge clk); load_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 t", t_o, 0);
      chk("R1 n1", n1_o, 0);
      chk("R1 n2", n2_o, 0);
      chk("R1 busy", busy_o, 0);
      chk("R1 done", done_o, 0);
   endtask

   task automatic t_single_step();
      logic [2*W-1:0] e;
      do_load(16'h0005, 16'h1234);
      chk("R2 n1", n1_o, 16'h0005);
      chk("R2 n2", n2_o, 16'h1234);
      chk("R2 t", t_o, 0);
      step_i = 1'b1; @(negedge clk); step_i = 1'b0;
      e = ref_step(16'h0, 16'h0005, 16'h1234);
      chk("R3 add step", prod_o, e);
      chk("R4 n2 kept", n2_o, 16'h1234);
      step_i = 1'b1; @(negedge clk); step_i = 1'b0;
      e = ref_step(e[2*W-1:W], e[W-1:0], 16'h1234);
      chk("R3 skip step", prod_o, e);
      // carry into MSB: T=0 loaded, force a large T by steps on all ones
      do_load(16'hFFFF, 16'hFFFF);
      step_i = 1'b1; @(negedge clk);
      @(negedge clk); step_i = 1'b0;
      e = ref_step(16'h0, 16'hFFFF, 16'hFFFF);
      e = ref_step(e[2*W-1:W], e[W-1:0], 16'hFFFF);
      chk("R3 carry step", prod_o, e);
   endtask

   task automatic t_manual_full(input logic [W-1:0] a, input logic [W-1:0] b);
      do_load(a, b);
      step_i = 1'b1;
      for (int i = 0; i < W; i++) @(negedge clk);
      step_i = 1'b0;
      chk("R5 product", prod_o, 64'(a) * 64'(b));
      chk("R4 n2 after steps", n2_o, b);
   endtask

   task automatic t_sequence(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
      mplier_i = a; mcand_i = b; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk("R6 busy after start", busy_o, 1);
      for (int k = 2; k <= W + 3; k++) begin
         if (disturb && k == 5) begin
            start_i = 1'b1; load_i = 1'b1; step_i = 1'b1;
            mplier_i = 16'h7777; mcand_i = 16'h0003;
         end
         if (disturb && k == 6) begin
            start_i = 1'b0; load_i = 1'b0; step_i = 1'b0;
         end
         @(negedge clk);
         if (k == W + 2) chk("R6 done not early", done_o, 0);
      end
      chk("R6 done", done_o, 1);
      chk("R6 busy low", busy_o, 0);
      chk(disturb ? "R8 product kept" : "R7 product", prod_o, 64'(a) * 64'(b));
      chk("R7 n2 dropped", n2_o, 0);
      @(negedge clk);
      chk("R6 done one cycle", done_o, 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single_step();
      t_manual_full(16'h00FF, 16'h0101);
      t_manual_full(16'hFFFF, 16'hFFFF);
      t_manual_full(16'h8000, 16'h0002);
      t_sequence(16'h1234, 16'h5678, 1'b0);
      t_sequence(16'hFFFF, 16'hFFFF, 1'b0);
      t_sequence(16'hABCD, 16'h00EF, 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule